// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads up to two descriptor words from a page table held in memory. A request brings a virtual address and the base of the first-level table. The walker reads one first-level descriptor and decodes its low two bits. The descriptor can resolve the translation at once, as a 1 MB section or a 16 MB supersection. It can point to a coarse second-level table of 256 word entries, whose descriptor then resolves to a 4 KB or a 64 KB page. An encoding that fits neither path ends the walk with a translation fault.

Memory reads use a simple port. The address is held while the walker waits for the read to be accepted, and one data word comes back later on a response strobe. Every fault sets a pending bit in a five-bit event field, at bit 1. The same cycle also captures the faulting virtual address. Software-style control inputs acknowledge pending bits, and set or clear their enable bits. The interrupt line is raised while any pending bit is also enabled. A walk-enable input can turn the walker off. In that case every request ends as a fault and no memory is read.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, req_ready is 1, and mem_rd_valid, rsp_valid, irq, evt_status, evt_enable and fault_addr are all 0.
- R2: The first memory read is at req_base + 4 * req_va[31:20]. mem_rd_valid and mem_rd_addr stay unchanged until mem_rd_ready is seen.
- R3: A first-level descriptor whose bits 1:0 are 01 starts a second read, at {desc[31:10], va[19:12], 2'b00}.
- R4: A first-level descriptor whose bits 1:0 are 10 and whose bit 18 is 0 returns rsp_size 3 (1 MB) with rsp_pa = {desc[31:20], va[19:0]}, after exactly one read.
- R5: A first-level descriptor whose bits 1:0 are 10 and whose bit 18 is 1 returns rsp_size 4 (16 MB) with rsp_pa = {desc[31:24], va[23:0]}.
- R6: A second-level descriptor with bit 1 set returns rsp_size 1 (4 KB) with rsp_pa = {desc[31:12], va[11:0]}.
- R7: A second-level descriptor with bits 1:0 equal to 01 returns rsp_size 2 (64 KB) with rsp_pa = {desc[31:16], va[15:0]}.
- R8: Three encodings end the walk as a fault: a first-level descriptor with bits 1:0 of 00, one with bits 1:0 of 11, and a second-level descriptor with bits 1:0 of 00. The response then has rsp_fault 1, rsp_size 0 and rsp_pa 0.
- R9: A fault response, held for one cycle, sets evt_status[1] and loads fault_addr with the request's virtual address. Both are visible from the next cycle.
- R10: While walk_en is 0, an accepted request gives a fault response in the very next cycle and issues no memory read.
- R11: evt_ack_we with a 1 in a bit of evt_ack_mask clears that pending bit, and a 0 leaves it untouched. A fault arriving in the same cycle as an ack of its bit leaves the bit set.
- R12: evt_set_we sets and evt_clr_we clears the enable bits named in their masks; set wins if both name a bit. irq is 1 exactly when some bit is pending and enabled.
- R13: req_ready is 0 from the cycle after a request is accepted until the walk ends. A request offered in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_en | input | 1 | Walker enable; 0 turns every request into a fault |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base address |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory read accepted |
| mem_rd_addr | output | 32 | Memory read word address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data (descriptor) |
| rsp_valid | output | 1 | Translation result, one cycle |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_size | output | 3 | 0 none, 1 4 KB, 2 64 KB, 3 1 MB, 4 16 MB |
| rsp_fault | output | 1 | Translation fault |
| evt_ack_we | input | 1 | Acknowledge pending bits |
| evt_ack_mask | input | 5 | Bits to acknowledge |
| evt_set_we | input | 1 | Enable-set strobe |
| evt_set_mask | input | 5 | Enable bits to set |
| evt_clr_we | input | 1 | Enable-clear strobe |
| evt_clr_mask | input | 5 | Enable bits to clear |
| evt_status | output | 5 | Pending event bits; bit 1 is the translation fault |
| evt_enable | output | 5 | Event enable bits |
| fault_addr | output | 32 | Virtual address of the last fault |
| irq | output | 1 | Interrupt: any pending bit that is enabled |

## Verification
A new fault can set the pending bit in the same cycle that an acknowledge clears it. The bench raises the acknowledge of bit 1 in exactly the cycle where a fault response is shown, with walk_en low so that the fault falls on a known cycle. It then checks that the pending bit is still 1 one cycle later. It also checks that fault_addr holds the new address. Only an acknowledge given in a later cycle may clear the bit. In the same way, an enable set and an enable clear on one bit are given together, and the bench checks that the set wins.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int unsigned AW = 32;

  typedef enum logic [2:0] {
    PG_NONE = 3'd0,
    PG_4K   = 3'd1,
    PG_64K  = 3'd2,
    PG_1M   = 3'd3,
    PG_16M  = 3'd4
  } pg_size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } walk_st_e;

  // first-level slot: one word per megabyte of virtual space
  function automatic logic [AW-1:0] l1_slot(input logic [AW-1:0] base, input logic [AW-1:0] va);
    return base + {18'd0, va[31:20], 2'b00};
  endfunction

  // second-level slot inside a 1 KB coarse table
  function automatic logic [AW-1:0] l2_slot(input logic [AW-1:0] desc, input logic [AW-1:0] va);
    return {desc[31:10], va[19:12], 2'b00};
  endfunction

  function automatic int unsigned page_shift(input pg_size_e sz);
    case (sz)
      PG_4K:   return 12;
      PG_64K:  return 16;
      PG_1M:   return 20;
      PG_16M:  return 24;
      default: return 0;
    endcase
  endfunction

  function automatic logic [AW-1:0] merge_pa(input logic [AW-1:0] desc, input logic [AW-1:0] va,
                                             input pg_size_e sz);
    logic [AW-1:0] m;
    m = (32'h1 << page_shift(sz)) - 32'h1;
    return (desc & ~m) | (va & m);
  endfunction
endpackage

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          walk_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_va,
  input  logic [AW-1:0] req_base,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_pa,
  output logic [2:0]    rsp_size,
  output logic          rsp_fault,
  output logic          fault_evt,
  output logic [AW-1:0] fault_va
);
  walk_st_e      st;
  logic [AW-1:0] va_q, base_q, desc_q, pa_q;
  pg_size_e      size_q;

  // named events for the checks
  logic accept, l1_beat, l2_beat;
  assign accept  = req_valid && req_ready;
  assign l1_beat = (st == ST_L1_WAIT) && mem_rsp_valid;
  assign l2_beat = (st == ST_L2_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      va_q   <= '0;
      base_q <= '0;
      desc_q <= '0;
      pa_q   <= '0;
      size_q <= PG_NONE;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          va_q   <= req_va;
          base_q <= req_base;
          st     <= walk_en ? ST_L1_REQ : ST_FAULT;
        end
        ST_L1_REQ: if (mem_rd_ready) st <= ST_L1_WAIT;
        ST_L1_WAIT: if (l1_beat) begin
          case (mem_rsp_data[1:0])
            2'b01: begin desc_q <= mem_rsp_data; st <= ST_L2_REQ; end
            2'b10: begin
              size_q <= mem_rsp_data[18] ? PG_16M : PG_1M;
              pa_q   <= merge_pa(mem_rsp_data, va_q, mem_rsp_data[18] ? PG_16M : PG_1M);
              st     <= ST_DONE;
            end
            default: st <= ST_FAULT;
          endcase
        end
        ST_L2_REQ: if (mem_rd_ready) st <= ST_L2_WAIT;
        ST_L2_WAIT: if (l2_beat) begin
          if (mem_rsp_data[1]) begin
            size_q <= PG_4K;
            pa_q   <= merge_pa(mem_rsp_data, va_q, PG_4K);
            st     <= ST_DONE;
          end else if (mem_rsp_data[0]) begin
            size_q <= PG_64K;
            pa_q   <= merge_pa(mem_rsp_data, va_q, PG_64K);
            st     <= ST_DONE;
          end else begin
            st <= ST_FAULT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == ST_IDLE);
  assign mem_rd_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign mem_rd_addr  = (st == ST_L2_REQ) ? l2_slot(desc_q, va_q) : l1_slot(base_q, va_q);
  assign rsp_valid    = (st == ST_DONE) || (st == ST_FAULT);
  assign rsp_fault    = (st == ST_FAULT);
  assign rsp_pa       = (st == ST_DONE) ? pa_q : '0;
  assign rsp_size     = (st == ST_DONE) ? size_q : PG_NONE;
  assign fault_evt    = (st == ST_FAULT);
  assign fault_va     = va_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R2
  AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !walk_en |=> rsp_valid && rsp_fault && !mem_rd_valid); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R13
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R13
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_pa == '0 && rsp_size == PG_NONE); // R8
endmodule

// File: rtl/pgwalk_evt.sv
module pgwalk_evt #(
  parameter int unsigned EVT_W     = 5,
  parameter int unsigned FAULT_EVT = 1,
  parameter int unsigned AW        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_evt,
  input  logic [AW-1:0]    fault_va,
  input  logic             ack_we,
  input  logic [EVT_W-1:0] ack_mask,
  input  logic             set_we,
  input  logic [EVT_W-1:0] set_mask,
  input  logic             clr_we,
  input  logic [EVT_W-1:0] clr_mask,
  output logic [EVT_W-1:0] status,
  output logic [EVT_W-1:0] enable,
  output logic [AW-1:0]    fault_addr,
  output logic             irq
);
  logic [EVT_W-1:0] raise;

  for (genvar b = 0; b < EVT_W; b++) begin : g_evt
    assign raise[b] = (b == FAULT_EVT) ? fault_evt : 1'b0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status[b] <= 1'b0;
        enable[b] <= 1'b0;
      end else begin
        // a new event outranks an acknowledge in the same cycle
        if (raise[b])                    status[b] <= 1'b1;
        else if (ack_we && ack_mask[b])  status[b] <= 1'b0;
        if (set_we && set_mask[b])       enable[b] <= 1'b1;
        else if (clr_we && clr_mask[b])  enable[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fault_addr <= '0;
    else if (fault_evt) fault_addr <= fault_va;
  end

  assign irq = |(status & enable);

  AST_FAULT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> status[FAULT_EVT]); // R9
  AST_FAULT_ADDR_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> fault_addr == $past(fault_va)); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we && ack_mask[FAULT_EVT] && !fault_evt |=> !status[FAULT_EVT]); // R11
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[FAULT_EVT] && !(ack_we && ack_mask[FAULT_EVT]) |=> status[FAULT_EVT]); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we && set_mask[FAULT_EVT] |=> enable[FAULT_EVT]); // R12
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned EVT_W     = 5,
  parameter int unsigned FAULT_EVT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_va,
  input  logic [31:0]      req_base,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [31:0]      mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             rsp_valid,
  output logic [31:0]      rsp_pa,
  output logic [2:0]       rsp_size,
  output logic             rsp_fault,
  input  logic             evt_ack_we,
  input  logic [EVT_W-1:0] evt_ack_mask,
  input  logic             evt_set_we,
  input  logic [EVT_W-1:0] evt_set_mask,
  input  logic             evt_clr_we,
  input  logic [EVT_W-1:0] evt_clr_mask,
  output logic [EVT_W-1:0] evt_status,
  output logic [EVT_W-1:0] evt_enable,
  output logic [31:0]      fault_addr,
  output logic             irq
);
  logic          fault_evt;
  logic [AW-1:0] fault_va;

  pgwalk_fsm u_fsm (
    .clk, .rst_n, .walk_en, .req_valid, .req_ready, .req_va, .req_base,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
    .rsp_valid, .rsp_pa, .rsp_size, .rsp_fault, .fault_evt, .fault_va
  );

  pgwalk_evt #(.EVT_W(EVT_W), .FAULT_EVT(FAULT_EVT), .AW(AW)) u_evt (
    .clk, .rst_n, .fault_evt, .fault_va,
    .ack_we(evt_ack_we), .ack_mask(evt_ack_mask),
    .set_we(evt_set_we), .set_mask(evt_set_mask),
    .clr_we(evt_clr_we), .clr_mask(evt_clr_mask),
    .status(evt_status), .enable(evt_enable), .fault_addr, .irq
  );

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_status != '0) && (evt_enable != '0)); // R12
endmodule

// File: tb/pgwalk_tb.sv
module pgwalk_top_tb_top;
  logic clk = 0, rst_n = 0, walk_en = 1;
  logic req_valid = 0, mem_rd_ready = 0, mem_rsp_valid = 0;
  logic [31:0] req_va = 0, req_base = 0, mem_rsp_data = 0;
  logic evt_ack_we = 0, evt_set_we = 0, evt_clr_we = 0;
  logic [4:0] evt_ack_mask = 0, evt_set_mask = 0, evt_clr_mask = 0;
  logic req_ready, mem_rd_valid, rsp_valid, rsp_fault, irq;
  logic [31:0] mem_rd_addr, rsp_pa, fault_addr;
  logic [2:0] rsp_size;
  logic [4:0] evt_status, evt_enable;

  int checks = 0, fails = 0, rd_cnt = 0, stall = 0, lat = 0;
  logic [31:0] mem_words [logic [31:0]];

  always #5 clk = ~clk;

  pgwalk_top dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_l1(input logic [31:0] base, input logic [31:0] va);
    return base + ((va >> 20) << 2);
  endfunction
  function automatic logic [31:0] e_l2(input logic [31:0] d, input logic [31:0] va);
    return {d[31:10], 10'd0} | {22'd0, va[19:12], 2'b00};
  endfunction

  // memory responder: optional stall before accepting, data on the next cycle
  initial forever begin
    @(negedge clk);
    if (mem_rd_valid) begin
      logic [31:0] a;
      a = mem_rd_addr;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_rd_valid && mem_rd_addr == a, "R2 hold", mem_rd_addr, a);
      end
      mem_rd_ready = 1;
      @(negedge clk);
      mem_rd_ready = 0;
      mem_rsp_data = mem_words.exists(a) ? mem_words[a] : 32'h0;
      mem_rsp_valid = 1;
      rd_cnt++;
      @(negedge clk);
      mem_rsp_valid = 0;
    end
  end

  task automatic send(input logic [31:0] va, input logic [31:0] base, input bit wen);
    while (!req_ready) @(negedge clk);
    walk_en = wen; req_va = va; req_base = base; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit wen,
                      input logic [31:0] epa, input logic [2:0] esz, input bit eflt,
                      input int ereads, input string req);
    int r0;
    r0 = rd_cnt;
    send(va, base, wen);
    chk(rsp_valid, req, {31'd0, rsp_valid}, 1);
    chk(rsp_fault == eflt, req, {31'd0, rsp_fault}, {31'd0, eflt});
    chk(rsp_pa == epa, req, rsp_pa, epa);
    chk(rsp_size == esz, req, {29'd0, rsp_size}, {29'd0, esz});
    chk(rd_cnt - r0 == ereads, req, rd_cnt - r0, ereads);
    @(negedge clk);
    if (eflt) begin
      chk(evt_status[1], "R9 pend", {27'd0, evt_status}, 32'h2);
      chk(fault_addr == va, "R9 addr", fault_addr, va);
      evt_ack_we = 1; evt_ack_mask = 5'b00010;
      @(negedge clk);
      evt_ack_we = 0;
    end
  endtask

  task automatic t_reset;
    chk(req_ready && !mem_rd_valid && !rsp_valid && !irq, "R1 ctl",
        {28'd0, req_ready, mem_rd_valid, rsp_valid, irq}, 32'h8);
    chk(evt_status == 0 && evt_enable == 0 && fault_addr == 0, "R1 evt", fault_addr, 0);
  endtask

  task automatic t_sections;
    logic [31:0] b = 32'h8000_0000;
    mem_words[e_l1(b, 32'h1234_5678)] = 32'hABC0_0C02;
    walk(32'h1234_5678, b, 1, 32'hABC4_5678, 3, 0, 1, "R4 1MB");
    mem_words[e_l1(b, 32'h4567_89AB)] = 32'h9A04_0002;
    walk(32'h4567_89AB, b, 1, 32'h9A67_89AB, 4, 0, 1, "R5 16MB");
  endtask

  task automatic t_pages;
    logic [31:0] b = 32'h8000_0000, d1 = 32'h7000_1401;
    mem_words[e_l1(b, 32'h0FED_CBA9)] = d1;
    mem_words[e_l2(d1, 32'h0FED_CBA9)] = 32'h5555_6002;
    walk(32'h0FED_CBA9, b, 1, 32'h5555_6BA9, 1, 0, 2, "R3 R6 4KB");
    mem_words[e_l2(d1, 32'h0FE3_4567)] = 32'h3333_0001;
    walk(32'h0FE3_4567, b, 1, 32'h3333_4567, 2, 0, 2, "R3 R7 64KB");
  endtask

  task automatic t_faults;
    logic [31:0] b = 32'h8000_0000;
    walk(32'h2000_0000, b, 1, 0, 0, 1, 1, "R8 l1 00");
    mem_words[e_l1(b, 32'h3000_0000)] = 32'h1234_0003;
    walk(32'h3000_0000, b, 1, 0, 0, 1, 1, "R8 l1 11");
    walk(32'h0FE5_0000, b, 1, 0, 0, 1, 2, "R8 l2 00");
  endtask

  task automatic t_stall;
    logic [31:0] b = 32'h0010_0000;
    mem_words[e_l1(b, 32'h0056_789A)] = 32'hC010_0002;
    stall = 3;
    walk(32'h0056_789A, b, 1, 32'hC016_789A, 3, 0, 1, "R2 stall");
    stall = 0;
  endtask

  task automatic t_disabled;
    walk(32'hDEAD_B000, 32'h8000_0000, 0, 0, 0, 1, 0, "R10 off");
    chk(lat == 1, "R10 latency", lat, 1);
    walk_en = 1;
  endtask

  task automatic t_same_cycle_ack;
    send(32'h0BAD_0000, 32'h8000_0000, 0);
    evt_ack_we = 1; evt_ack_mask = 5'b00010;
    @(negedge clk);
    evt_ack_we = 0;
    chk(evt_status[1], "R11 set wins", {27'd0, evt_status}, 32'h2);
    chk(fault_addr == 32'h0BAD_0000, "R9 addr", fault_addr, 32'h0BAD_0000);
    evt_ack_we = 1; evt_ack_mask = 5'b11101;
    @(negedge clk);
    evt_ack_we = 0;
    chk(evt_status[1], "R11 zero bit", {27'd0, evt_status}, 32'h2);
    evt_ack_we = 1; evt_ack_mask = 5'b00010;
    @(negedge clk);
    evt_ack_we = 0;
    chk(evt_status == 0, "R11 clear", {27'd0, evt_status}, 0);
    walk_en = 1;
  endtask

  task automatic t_irq;
    send(32'h0F00_0000, 32'h8000_0000, 0);
    @(negedge clk);
    chk(!irq && evt_status[1], "R12 masked", {31'd0, irq}, 0);
    evt_set_we = 1; evt_set_mask = 5'b00010; evt_clr_we = 1; evt_clr_mask = 5'b00010;
    @(negedge clk);
    evt_set_we = 0; evt_clr_we = 0;
    chk(evt_enable == 5'b00010 && irq, "R12 set wins", {27'd0, evt_enable}, 32'h2);
    evt_clr_we = 1; evt_clr_mask = 5'b00010;
    @(negedge clk);
    evt_clr_we = 0;
    chk(!irq && evt_enable == 0, "R12 clear", {31'd0, irq}, 0);
    evt_set_we = 1; evt_set_mask = 5'b00010;
    evt_ack_we = 1; evt_ack_mask = 5'b00010;
    @(negedge clk);
    evt_set_we = 0; evt_ack_we = 0;
    chk(!irq && evt_status == 0, "R12 acked", {31'd0, irq}, 0);
    walk_en = 1;
  endtask

  task automatic t_busy;
    logic [31:0] b = 32'h8000_0000;
    int r0;
    r0 = rd_cnt;
    stall = 2;
    while (!req_ready) @(negedge clk);
    req_va = 32'h1234_5678; req_base = b; req_valid = 1;
    @(negedge clk);
    chk(!req_ready, "R13 busy", {31'd0, req_ready}, 0);
    req_va = 32'h4567_89AB;
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_pa == 32'hABC4_5678, "R13 ignored", rsp_pa, 32'hABC4_5678);
    @(negedge clk);
    repeat (6) @(negedge clk);
    chk(rd_cnt - r0 == 1, "R13 reads", rd_cnt - r0, 1);
    stall = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sections();
    t_pages();
    t_faults();
    t_stall();
    t_disabled();
    t_same_cycle_ack();
    t_irq();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule